// File: doc/BRIEF.md
# Fail-Safe Power Mode Sequencer

This block is the mode controller of a system-basis companion device. It moves between four power modes: Start-up, Normal, Standby and Sleep. It takes single-cycle mode requests and interrupt-register read strobes from an SPI decoder. It also takes wake events from bus activity, a local wake pin, a rise in supply current and a supply overload, together with the watchdog overflow. From these it drives the microcontroller reset, the enable output, the open-drain interrupt, the main regulator enable and the inhibit output enable.

A pending interrupt must be read by software within a fixed deadline, or the block forces a reset. In Standby, each wake source is set by its own configuration bit to wake through an interrupt or through a reset. In Sleep, every enabled wake source returns the system through a reset. A 3-bit code records the cause of the last forced reset.

Top module: `fs_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and immediately after it, the mode is Start-up (`mode_o`=0), `rstn_o` is low, `rst_src` is 0 (power-on) and `wake_flags` is 0. The block stays in Start-up with `rstn_o` low for RST_CYC cycles and then enters Standby (`mode_o`=2) with `rstn_o` high.
- R2: Mode codes are 0 Start-up, 1 Normal, 2 Standby and 3 Sleep. In Standby, `req_normal` selects Normal. In Normal, `req_standby` selects Standby. In either of these modes, `req_sleep` selects Sleep and takes priority over the other requests. Any other request is ignored, and all requests and events are ignored in Start-up.
- R3: From the first cycle in which the mode is Sleep, `rstn_o`, `v1_en` and `inh_oe` are low.
- R4: In Sleep, bus activity (`can_act` or `lin_act`) wakes through a reset with code 3, and a wake-pin falling edge wakes through a reset with code 4. A watchdog overflow wakes through a reset with code 1 when `wd_off` is 0 and is ignored when `wd_off` is 1.
- R5: `v3_mode` is coded 0 off, 1 on and 2 cyclic. When `v3_mode` is non-zero, a supply overload wakes Sleep through a reset with code 5 and sets flag bit 4 in Normal or Standby. When `v3_mode` is 0, the overload is ignored.
- R6: In Standby, `wake_cfg` bit 0 (watchdog), bit 1 (bus), bit 2 (wake pin) and bit 3 (current rise) each select between a reset (1) and a flag (0). The reset codes are 1, 3, 4 and 6. In Normal, a watchdog overflow always resets with code 1, and bus, pin and current-rise events set flags.
- R7: `wake_flags` uses bit 0 for watchdog, bit 1 for bus, bit 2 for wake pin, bit 3 for current rise and bit 4 for overload. Flags are sticky. `irq_read` clears them, but an event in the same cycle as the read leaves its own bit set. `intn_drv` is high whenever any flag is set.
- R8: In Normal or Standby, if flags stay non-zero with no `irq_read` for IRQ_TMO cycles, the block forces a reset into Start-up with code 2.
- R9: `en_o` is low whenever `rstn_o` is low or `wd_ovf` is high.
- R10: `wake_pin` passes through two synchronizing flops. A falling edge takes effect at the third clock edge after the pin is sampled low, and it counts once per fall.
- R11: When several reset causes occur in the same cycle, the recorded code follows this order: watchdog, then deadline timeout, then bus, then wake pin, then current rise, then overload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| req_normal | input | 1 | Request Normal mode (pulse) |
| req_standby | input | 1 | Request Standby mode (pulse) |
| req_sleep | input | 1 | Request Sleep mode (pulse) |
| irq_read | input | 1 | Interrupt register read strobe; clears flags |
| wake_cfg | input | 4 | Per-source wake action in Standby (1 = reset) |
| wd_off | input | 1 | Watchdog disabled while in Sleep |
| v3_mode | input | 2 | Auxiliary supply mode: 0 off, 1 on, 2 cyclic |
| wd_ovf | input | 1 | Watchdog overflow pulse |
| can_act | input | 1 | CAN bus activity detected |
| lin_act | input | 1 | LIN bus activity detected |
| wake_pin | input | 1 | Asynchronous local wake pin |
| cur_rise | input | 1 | Microcontroller supply current rise |
| v3_ovl | input | 1 | Auxiliary supply overload |
| mode_o | output | 2 | Current mode code |
| rstn_o | output | 1 | Microcontroller reset, active low |
| en_o | output | 1 | Enable output |
| intn_drv | output | 1 | Pull-down enable of the open-drain interrupt |
| v1_en | output | 1 | Main regulator enable |
| inh_oe | output | 1 | Inhibit output drive enable |
| rst_src | output | 3 | Cause of the last reset |
| wake_flags | output | 5 | Sticky wake/interrupt flags |

## Verification
Two collisions matter most in this block. The first is the interrupt-read deadline expiring in the same cycle as a wake event that is configured to reset. The bench provokes it by setting a flag, waiting exactly IRQ_TMO-1 cycles and then pulsing bus activity, and it expects code 2 rather than 3. The second is a register read landing in the same cycle as a new wake event. Here the bench expects the old flags to clear while the new bit survives. Both cases, and a long random stretch that produces further collisions, are judged against a behavioural model on every clock.

// File: rtl/fs_mode_ctrl.sv
module fs_mode_ctrl #(
  parameter int RST_CYC = 16,
  parameter int IRQ_TMO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_normal,
  input  logic       req_standby,
  input  logic       req_sleep,
  input  logic       irq_read,
  input  logic [3:0] wake_cfg,
  input  logic       wd_off,
  input  logic [1:0] v3_mode,
  input  logic       wd_ovf,
  input  logic       can_act,
  input  logic       lin_act,
  input  logic       wake_pin,
  input  logic       cur_rise,
  input  logic       v3_ovl,
  output logic [1:0] mode_o,
  output logic       rstn_o,
  output logic       en_o,
  output logic       intn_drv,
  output logic       v1_en,
  output logic       inh_oe,
  output logic [2:0] rst_src,
  output logic [4:0] wake_flags
);
  localparam logic [1:0] M_START = 2'd0, M_NORM = 2'd1, M_STBY = 2'd2, M_SLEEP = 2'd3;
  localparam int CMAX = (RST_CYC > IRQ_TMO) ? RST_CYC : IRQ_TMO;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] START_END = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] TMO_END = CW'(IRQ_TMO - 1);

  logic [1:0]    mode;
  logic [CW-1:0] cnt;
  logic [2:0]    src;
  logic [4:0]    flags;
  logic [2:0]    pin_s;

  wire act     = (mode == M_NORM) || (mode == M_STBY);
  wire sb      = mode == M_STBY;
  wire slp     = mode == M_SLEEP;
  wire bus     = can_act | lin_act;
  wire pin_fall = pin_s[2] & ~pin_s[1];
  wire v3_live = v3_mode != 2'd0;
  wire pend    = |flags;
  wire timeout = act && pend && !irq_read && (cnt == TMO_END);

  wire r_wd  = wd_ovf && ((mode == M_NORM) || (sb && wake_cfg[0]) || (slp && !wd_off));
  wire r_bus = bus && ((sb && wake_cfg[1]) || slp);
  wire r_pin = pin_fall && ((sb && wake_cfg[2]) || slp);
  wire r_cur = cur_rise && sb && wake_cfg[3];
  wire r_ovl = v3_ovl && v3_live && slp;
  wire force_rst = r_wd | timeout | r_bus | r_pin | r_cur | r_ovl;

  logic [2:0] src_n;
  always_comb begin
    if (r_wd)         src_n = 3'd1;
    else if (timeout) src_n = 3'd2;
    else if (r_bus)   src_n = 3'd3;
    else if (r_pin)   src_n = 3'd4;
    else if (r_cur)   src_n = 3'd6;
    else              src_n = 3'd5;
  end

  wire [4:0] new_f = {
    v3_ovl && v3_live && act,
    cur_rise && act && !(sb && wake_cfg[3]),
    pin_fall && act && !(sb && wake_cfg[2]),
    bus && act && !(sb && wake_cfg[1]),
    wd_ovf && sb && !wake_cfg[0]
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_s <= 3'b111;
    else        pin_s <= {pin_s[1:0], wake_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (irq_read ? 5'd0 : flags) | new_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_START;
      cnt  <= '0;
      src  <= 3'd0;
    end else if (force_rst) begin
      mode <= M_START;
      cnt  <= '0;
      src  <= src_n;
    end else begin
      case (mode)
        M_START: begin
          if (cnt == START_END) begin
            mode <= M_STBY;
            cnt  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        M_NORM, M_STBY: begin
          if (req_sleep) begin
            mode <= M_SLEEP;
            cnt  <= '0;
          end else begin
            if (mode == M_NORM && req_standby) mode <= M_STBY;
            if (mode == M_STBY && req_normal)  mode <= M_NORM;
            cnt <= (pend && !irq_read) ? cnt + 1'b1 : '0;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign mode_o     = mode;
  assign rstn_o     = act;
  assign en_o       = act & ~wd_ovf;
  assign intn_drv   = pend;
  assign v1_en      = ~slp;
  assign inh_oe     = ~slp;
  assign rst_src    = src;
  assign wake_flags = flags;

  p_start_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_START && cnt == START_END) |=> (mode == M_STBY && rstn_o));

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && req_sleep && !force_rst) |=> (!rstn_o && !v1_en && !inh_oe));

  p_ovl_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slp && v3_ovl && v3_mode == 2'd0 && !bus && !pin_fall && !(wd_ovf && !wd_off))
      |=> (mode_o == M_SLEEP));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_read |=> ((wake_flags & $past(wake_flags)) == $past(wake_flags)));

  p_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !r_wd) |=> (mode_o == M_START && rst_src == 3'd2));

  p_wd_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r_wd |=> (rst_src == 3'd1 && !rstn_o));
endmodule

// File: tb/test_fs_mode_ctrl.sv
module test_fs_mode_ctrl;
  localparam int RC = 8;
  localparam int TM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_normal = 0, req_standby = 0, req_sleep = 0, irq_read = 0;
  logic [3:0] wake_cfg = 4'h0;
  logic wd_off = 0;
  logic [1:0] v3_mode = 2'd0;
  logic wd_ovf = 0, can_act = 0, lin_act = 0, wake_pin = 1, cur_rise = 0, v3_ovl = 0;
  logic [1:0] mode_o;
  logic rstn_o, en_o, intn_drv, v1_en, inh_oe;
  logic [2:0] rst_src;
  logic [4:0] wake_flags;

  fs_mode_ctrl #(.RST_CYC(RC), .IRQ_TMO(TM)) i_fs_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_normal(req_normal), .req_standby(req_standby),
    .req_sleep(req_sleep), .irq_read(irq_read), .wake_cfg(wake_cfg), .wd_off(wd_off),
    .v3_mode(v3_mode), .wd_ovf(wd_ovf), .can_act(can_act), .lin_act(lin_act),
    .wake_pin(wake_pin), .cur_rise(cur_rise), .v3_ovl(v3_ovl), .mode_o(mode_o),
    .rstn_o(rstn_o), .en_o(en_o), .intn_drv(intn_drv), .v1_en(v1_en), .inh_oe(inh_oe),
    .rst_src(rst_src), .wake_flags(wake_flags));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  int m_mode, m_cnt, m_src, m_flags;
  int hist[$];

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_src = 0; m_flags = 0;
      hist = '{1, 1, 1};
    end else begin
      int code, nf, busy;
      bit fall, awake, stby, sleeping, tmo;
      fall = (hist[2] == 1) && (hist[1] == 0);
      awake = (m_mode == 1) || (m_mode == 2);
      stby = m_mode == 2;
      sleeping = m_mode == 3;
      busy = can_act || lin_act;
      tmo = awake && m_flags != 0 && !irq_read && m_cnt == TM - 1;
      code = -1;
      nf = 0;
      if (wd_ovf && (m_mode == 1 || (stby && wake_cfg[0]) || (sleeping && !wd_off))) code = 1;
      else if (tmo) code = 2;
      else if (busy != 0 && ((stby && wake_cfg[1]) || sleeping)) code = 3;
      else if (fall && ((stby && wake_cfg[2]) || sleeping)) code = 4;
      else if (cur_rise && stby && wake_cfg[3]) code = 6;
      else if (v3_ovl && v3_mode != 0 && sleeping) code = 5;
      if (awake) begin
        if (stby && wd_ovf && !wake_cfg[0]) nf += 1;
        if (busy != 0 && !(stby && wake_cfg[1])) nf += 2;
        if (fall && !(stby && wake_cfg[2])) nf += 4;
        if (cur_rise && !(stby && wake_cfg[3])) nf += 8;
        if (v3_ovl && v3_mode != 0) nf += 16;
      end
      if (code >= 0) begin
        m_mode = 0; m_cnt = 0; m_src = code;
      end else if (m_mode == 0) begin
        if (m_cnt == RC - 1) begin m_mode = 2; m_cnt = 0; end
        else m_cnt++;
      end else if (awake) begin
        if (req_sleep) begin m_mode = 3; m_cnt = 0; end
        else begin
          if (m_mode == 1 && req_standby) m_mode = 2;
          else if (m_mode == 2 && req_normal) m_mode = 1;
          m_cnt = (m_flags != 0 && !irq_read) ? m_cnt + 1 : 0;
        end
      end
      m_flags = (irq_read ? 0 : m_flags) | nf;
      hist.push_front(int'(wake_pin));
      void'(hist.pop_back());
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit awake;
      cycles++;
      awake = (m_mode == 1) || (m_mode == 2);
      cmp("mode", int'(mode_o), m_mode);
      cmp("rstn", int'(rstn_o), int'(awake));
      cmp("en (R9)", int'(en_o), int'(awake && !wd_ovf));
      cmp("intn", int'(intn_drv), int'(m_flags != 0));
      cmp("v1_en", int'(v1_en), int'(m_mode != 3));
      cmp("inh_oe", int'(inh_oe), int'(m_mode != 3));
      cmp("rst_src", int'(rst_src), m_src);
      cmp("flags", int'(wake_flags), m_flags);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr;
    req_normal = 0; req_standby = 0; req_sleep = 0; irq_read = 0;
    wd_ovf = 0; can_act = 0; lin_act = 0; cur_rise = 0; v3_ovl = 0;
  endtask

  task automatic to_standby;
    tick(RC + 2);
    irq_read = 1; tick(1); clr;
  endtask

  task automatic to_sleep;
    req_sleep = 1; tick(1); clr; tick(2);
  endtask

  task automatic pin_pulse;
    wake_pin = 0; tick(4); wake_pin = 1; tick(4);
  endtask

  initial begin
    phase = "R1";
    tick(3);
    rst_n = 1;
    tick(RC + 3);
    phase = "R2";
    req_normal = 1; tick(1); clr; tick(2);
    req_normal = 1; tick(1); clr; tick(2);
    req_standby = 1; tick(1); clr; tick(2);
    req_standby = 1; tick(1); clr; tick(2);
    req_normal = 1; tick(1); clr;
    req_standby = 1; req_sleep = 1; tick(1); clr; tick(3);
    phase = "R3";
    wd_off = 1; tick(3);
    phase = "R4";
    wd_ovf = 1; tick(1); clr; tick(2);
    wd_off = 0; wd_ovf = 1; tick(1); clr;
    to_standby;
    to_sleep; can_act = 1; tick(1); clr; to_standby;
    to_sleep; lin_act = 1; tick(1); clr; to_standby;
    phase = "R10";
    to_sleep; pin_pulse; to_standby;
    phase = "R5";
    to_sleep; v3_mode = 0; v3_ovl = 1; tick(1); clr; tick(3);
    v3_mode = 2; v3_ovl = 1; tick(1); clr; to_standby;
    v3_mode = 1; v3_ovl = 1; tick(1); clr; tick(2);
    v3_mode = 0; v3_ovl = 1; tick(1); clr; irq_read = 1; tick(1); clr;
    phase = "R6";
    wake_cfg = 4'h0;
    wd_ovf = 1; tick(1); clr; can_act = 1; tick(1); clr; pin_pulse;
    cur_rise = 1; tick(1); clr; irq_read = 1; tick(1); clr;
    wake_cfg = 4'hF;
    wd_ovf = 1; tick(1); clr; to_standby;
    can_act = 1; tick(1); clr; to_standby;
    pin_pulse; to_standby;
    cur_rise = 1; tick(1); clr; to_standby;
    req_normal = 1; tick(1); clr; wake_cfg = 4'h0;
    can_act = 1; tick(1); clr; cur_rise = 1; tick(1); clr;
    irq_read = 1; tick(1); clr;
    wd_ovf = 1; tick(1); clr; to_standby;
    phase = "R7";
    lin_act = 1; tick(1); clr; tick(3);
    irq_read = 1; cur_rise = 1; tick(1); clr; tick(2);
    irq_read = 1; tick(1); clr; tick(2);
    phase = "R8";
    can_act = 1; tick(1); clr; tick(TM + 3);
    irq_read = 1; tick(1); clr; to_standby;
    phase = "R11";
    wake_cfg = 4'h2; cur_rise = 1; tick(1); clr; tick(TM - 1);
    can_act = 1; tick(1); clr; tick(RC + 2);
    irq_read = 1; tick(1); clr;
    wake_cfg = 4'hF; wake_pin = 0; tick(2);
    wd_ovf = 1; can_act = 1; cur_rise = 1; tick(1); clr; wake_pin = 1; to_standby;
    phase = "R9";
    wake_cfg = 4'h0; wd_ovf = 1; tick(1); clr; irq_read = 1; tick(1); clr;
    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      clr;
      if (i % 250 == 0) begin
        wake_cfg = 4'($urandom_range(0, 15));
        v3_mode = 2'($urandom_range(0, 2));
        wd_off = 1'($urandom_range(0, 1));
      end
      req_normal = ($urandom_range(0, 19) == 0);
      req_standby = ($urandom_range(0, 29) == 0);
      req_sleep = ($urandom_range(0, 59) == 0);
      irq_read = ($urandom_range(0, 14) == 0);
      wd_ovf = ($urandom_range(0, 79) == 0);
      can_act = ($urandom_range(0, 69) == 0);
      lin_act = ($urandom_range(0, 89) == 0);
      cur_rise = ($urandom_range(0, 69) == 0);
      v3_ovl = ($urandom_range(0, 79) == 0);
      if ($urandom_range(0, 9) == 0) wake_pin = ~wake_pin;
      tick(1);
    end
    clr;
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule